// File: doc/BRIEF.md
# Hash Engine Register Front End

This block sits between a 32-bit register bus and a hash compression engine that handles SHA-1 or MD5. The host programs the per-pass control word: algorithm, whether to start from the standard constants, whether to close the hash, and the pass length in bytes. It then pushes the message words through a sixteen-word input window. Once enough words have arrived, the block starts the engine with a one-cycle pulse. When the engine reports completion, the block latches the returned digest, advances the byte count and flags the result to the host.

A pass can resume an earlier computation instead of starting fresh. With the use-constants bit clear, the engine is fed the digest words and the byte count that the host last wrote. A soft reset, requested through the mask register, clears all state. The reset-done flag reads low until the reset sequence has finished.

Address map (byte offsets, word aligned):
- Digest words 0 to 4: 0x00 to 0x10.
- Byte count: 0x14.
- Control: 0x18.
- Input window words 0 to 15: 0x1C to 0x58.
- Revision: 0x5C.
- Mask: 0x60.
- Status: 0x64.

Top module: `hfe_front`

## Requirements
- R1: After reset, the digest words, byte count, control and mask registers all read 0, the status register reads 1, and irq, dma_req and eng_start are low.
- R2: The revision register reads the major revision in bits 7:4 and the minor revision in bits 3:0, with all other bits 0.
- R3: A control write while idle latches its fields, and if bits 31:5 are nonzero the input-ready flag (control bit 1) reads 1 from the next cycle. A write with length 0 leaves the block idle, with input-ready still 0.
- R4: A write to 0x1C+4*i during collection stores word i. After the N-th accepted write, eng_start is high for exactly one cycle and input-ready drops, where N = ceil(length/4) for lengths up to 64 and N = 16 above that. Words not written keep their earlier contents.
- R5: Input-window writes while input-ready is low are not stored and are not counted.
- R6: With control bit 3 set, the engine receives the standard initial words (words 0 to 3 are 67452301, EFCDAB89, 98BADCFE, 10325476; word 4 is C3D2E1F0 for SHA-1 and 0 for MD5) and a count of 0. With bit 3 clear, it receives the host-written digest words and byte count.
- R7: On engine completion, output-ready (control bit 0) reads 1, the digest words read the engine result, and the byte count reads the pass start count plus the pass length.
- R8: irq is high exactly while output-ready is 1 and the interrupt enable (mask bit 2) is 1.
- R9: Control writes are ignored while a pass is collecting or running. Once output-ready is set, only a control write with bit 0 set has an effect: it clears output-ready and returns the block to idle without changing the other fields.
- R10: Writing 1 to mask bit 1 starts a soft reset. Status bit 0 reads 0 for RST_CYCLES cycles, then reads 1, and all registers read as after R1.
- R11: dma_req is high exactly while input-ready is 1 and the DMA enable (mask bit 3) is 1.
- R12: Control bits 2 (1 = SHA-1), 3 (use constants), 4 (close hash) and 31:5 (length) read back as written, and are presented to the engine on eng_sha1, eng_close and eng_len.
- R13: Writes to the digest words and the byte count are ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | Input-window data request |
| eng_start | output | 1 | One-cycle engine start |
| eng_sha1 | output | 1 | Algorithm for the pass |
| eng_close | output | 1 | Apply final padding |
| eng_len | output | 27 | Pass length in bytes |
| eng_digest_in | output | 160 | Start digest, word 0 in bits 31:0 |
| eng_count_in | output | 32 | Start byte count |
| eng_block | output | 512 | Input window, word 0 in bits 31:0 |
| eng_done | input | 1 | Engine completion pulse |
| eng_digest_out | input | 160 | Engine result digest |

## Verification
The hardest cases to reach are writes that land in a state where they must be dropped: control writes in the middle of collection, digest writes while the engine is running, input-window writes while idle, and a soft reset that hits part-way through collection. Each random pass places a control write and a digest write between the control word and the first data word. Idle-time window writes are injected before passes. The result the bench predicts uses its own record of the window contents, so a stray stored word shows up as a wrong digest. One directed sequence starts a pass, writes two words and then fires the soft reset. It times the status flag cycle by cycle and checks that everything reads as cleared.

// File: rtl/hfe_pkg.sv
`timescale 1ns/1ps
package hfe_pkg;
    localparam int WORD_W    = 32;
    localparam int DIG_N     = 5;
    localparam int DIN_N     = 16;
    localparam int LEN_W     = WORD_W - 5;
    localparam int BLK_BYTES = DIN_N * 4;
    localparam int WCNT_W    = $clog2(DIN_N + 1);
    localparam int IDX_W     = $clog2(DIN_N);
    localparam int ADDR_W    = 7;

    localparam logic [ADDR_W-1:0] OFS_CNT  = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_DIN  = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_REV  = 7'h5C;
    localparam logic [ADDR_W-1:0] OFS_MASK = 7'h60;
    localparam logic [ADDR_W-1:0] OFS_STAT = 7'h64;

    localparam int CB_OUT   = 0;
    localparam int CB_IN    = 1;
    localparam int CB_ALGO  = 2;
    localparam int CB_INIT  = 3;
    localparam int CB_CLOSE = 4;
    localparam int CB_LEN   = 5;
    localparam int MB_IDLE  = 0;
    localparam int MB_SRST  = 1;
    localparam int MB_IE    = 2;
    localparam int MB_DMA   = 3;

    typedef enum logic [1:0] {PS_IDLE, PS_COLLECT, PS_RUN, PS_DONE} pass_state_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_DIG, RG_CNT, RG_CTRL, RG_DIN, RG_REV, RG_MASK, RG_STAT
    } reg_sel_e;

    typedef struct packed {
        logic [DIG_N-1:0][WORD_W-1:0] dig;
        logic [WORD_W-1:0]            cnt;
        logic                         sha1;
        logic                         init;
        logic                         close;
        logic [LEN_W-1:0]             len;
        logic                         auto_idle;
        logic                         irq_en;
        logic                         dma_en;
        logic [DIN_N-1:0][WORD_W-1:0] blk;
    } regs_t;

    function automatic logic [WORD_W-1:0] std_iv(input logic sha1, input int w);
        case (w)
            0:       return 32'h67452301;
            1:       return 32'hEFCDAB89;
            2:       return 32'h98BADCFE;
            3:       return 32'h10325476;
            4:       return sha1 ? 32'hC3D2E1F0 : 32'h0;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/hfe_addr_dec.sv
`timescale 1ns/1ps
module hfe_addr_dec
    import hfe_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-3:0] word_addr;
    logic [ADDR_W-3:0] din_word;

    assign word_addr = addr[ADDR_W-1:2];
    assign din_word  = word_addr - OFS_DIN[ADDR_W-1:2];

    always_comb begin
        sel = RG_NONE;
        idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr < OFS_CNT) begin
                sel = RG_DIG;
                idx = IDX_W'(word_addr);
            end else if (addr == OFS_CNT) begin
                sel = RG_CNT;
            end else if (addr == OFS_CTRL) begin
                sel = RG_CTRL;
            end else if (addr < OFS_REV) begin
                sel = RG_DIN;
                idx = IDX_W'(din_word);
            end else if (addr == OFS_REV) begin
                sel = RG_REV;
            end else if (addr == OFS_MASK) begin
                sel = RG_MASK;
            end else if (addr == OFS_STAT) begin
                sel = RG_STAT;
            end
        end
    end
endmodule

// File: rtl/hfe_soft_rst.sv
`timescale 1ns/1ps
module hfe_soft_rst #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (trig) begin
            cnt_d = CW'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_SRST_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10
    AST_SRST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt_q == CW'(RST_CYCLES))); // R10
endmodule

// File: rtl/hfe_pass_seq.sv
`timescale 1ns/1ps
module hfe_pass_seq
    import hfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic [WCNT_W-1:0] need,
    input  logic              din_wr,
    input  logic              ack_out,
    input  logic              eng_done,
    output pass_state_e       state,
    output logic              in_ready,
    output logic              out_ready,
    output logic              eng_start,
    output logic              pass_end,
    output logic              din_take
);
    typedef struct packed {
        pass_state_e       st;
        logic [WCNT_W-1:0] wcnt;
        logic              start;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        pass_end = 1'b0;
        unique case (q.st)
            PS_IDLE: begin
                if (go) begin
                    d.st   = PS_COLLECT;
                    d.wcnt = '0;
                end
            end
            PS_COLLECT: begin
                if (din_wr) begin
                    if (q.wcnt + 1'b1 == need) begin
                        d.st    = PS_RUN;
                        d.wcnt  = '0;
                        d.start = 1'b1;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            PS_RUN: begin
                if (eng_done && !q.start) begin
                    d.st     = PS_DONE;
                    pass_end = 1'b1;
                end
            end
            PS_DONE: begin
                if (ack_out) d.st = PS_IDLE;
            end
            default: d.st = PS_IDLE;
        endcase
        if (clr) begin
            d        = '{st: PS_IDLE, wcnt: '0, start: 1'b0};
            pass_end = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PS_IDLE, wcnt: '0, start: 1'b0};
        else        q <= d;
    end

    assign state     = q.st;
    assign in_ready  = (q.st == PS_COLLECT);
    assign out_ready = (q.st == PS_DONE);
    assign eng_start = q.start;
    assign din_take  = (q.st == PS_COLLECT) && din_wr;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R4
    AST_COLLECT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !clr) |=> (in_ready || eng_start)); // R4
    AST_OUT_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ready) |-> $past(eng_done)); // R7
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_IDLE) |-> (q.wcnt == '0)); // R5
endmodule

// File: rtl/hfe_front.sv
`timescale 1ns/1ps
module hfe_front
    import hfe_pkg::*;
#(
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] REV_MAJOR  = 4'd2,
    parameter logic [3:0] REV_MINOR  = 4'd1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    output logic                      irq,
    output logic                      dma_req,
    output logic                      eng_start,
    output logic                      eng_sha1,
    output logic                      eng_close,
    output logic [LEN_W-1:0]          eng_len,
    output logic [DIG_N*WORD_W-1:0]   eng_digest_in,
    output logic [WORD_W-1:0]         eng_count_in,
    output logic [DIN_N*WORD_W-1:0]   eng_block,
    input  logic                      eng_done,
    input  logic [DIG_N*WORD_W-1:0]   eng_digest_out
);
    regs_t                        q, d;
    reg_sel_e                     sel;
    logic [IDX_W-1:0]             idx;
    pass_state_e                  state;
    logic                         srst_busy, wr_ok, go, ack_out, srst_trig;
    logic                         din_wr, din_take, pass_end, in_ready, out_ready;
    logic [WCNT_W-1:0]            need;
    logic [DIG_N-1:0][WORD_W-1:0] base_dig;
    logic [WORD_W-1:0]            base_cnt;

    hfe_addr_dec u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    hfe_soft_rst #(.RST_CYCLES(RST_CYCLES)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (srst_trig),
        .busy  (srst_busy)
    );

    assign wr_ok     = bus_sel && bus_wr && !srst_busy;
    assign go        = wr_ok && (sel == RG_CTRL) && (state == PS_IDLE)
                       && (bus_wdata[WORD_W-1:CB_LEN] != '0);
    assign ack_out   = wr_ok && (sel == RG_CTRL) && (state == PS_DONE) && bus_wdata[CB_OUT];
    assign srst_trig = wr_ok && (sel == RG_MASK) && bus_wdata[MB_SRST];
    assign din_wr    = wr_ok && (sel == RG_DIN);

    always_comb begin
        if (q.len > LEN_W'(BLK_BYTES)) need = WCNT_W'(DIN_N);
        else                           need = WCNT_W'((q.len + LEN_W'(3)) >> 2);
    end

    hfe_pass_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_busy),
        .go        (go),
        .need      (need),
        .din_wr    (din_wr),
        .ack_out   (ack_out),
        .eng_done  (eng_done),
        .state     (state),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .eng_start (eng_start),
        .pass_end  (pass_end),
        .din_take  (din_take)
    );

    for (genvar w = 0; w < DIG_N; w++) begin : g_base
        assign base_dig[w] = q.init ? std_iv(q.sha1, w) : q.dig[w];
    end
    assign base_cnt = q.init ? '0 : q.cnt;

    always_comb begin
        d = q;
        if (wr_ok && (state == PS_IDLE)) begin
            case (sel)
                RG_DIG:  d.dig[idx[2:0]] = bus_wdata;
                RG_CNT:  d.cnt = bus_wdata;
                RG_CTRL: begin
                    d.sha1  = bus_wdata[CB_ALGO];
                    d.init  = bus_wdata[CB_INIT];
                    d.close = bus_wdata[CB_CLOSE];
                    d.len   = bus_wdata[WORD_W-1:CB_LEN];
                end
                default: ;
            endcase
        end
        if (wr_ok && (sel == RG_MASK)) begin
            d.auto_idle = bus_wdata[MB_IDLE];
            d.irq_en    = bus_wdata[MB_IE];
            d.dma_en    = bus_wdata[MB_DMA];
        end
        if (din_take) d.blk[idx] = bus_wdata;
        if (pass_end) begin
            d.dig = eng_digest_out;
            d.cnt = base_cnt + WORD_W'(q.len);
        end
        if (srst_busy) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (sel)
            RG_DIG:  bus_rdata = q.dig[idx[2:0]];
            RG_CNT:  bus_rdata = q.cnt;
            RG_CTRL: bus_rdata = {q.len, q.close, q.init, q.sha1, in_ready, out_ready};
            RG_REV:  bus_rdata = {24'b0, REV_MAJOR, REV_MINOR};
            RG_MASK: bus_rdata = {28'b0, q.dma_en, q.irq_en, 1'b0, q.auto_idle};
            RG_STAT: bus_rdata = {31'b0, !srst_busy};
            default: bus_rdata = '0;
        endcase
    end

    assign irq           = out_ready && q.irq_en;
    assign dma_req       = in_ready && q.dma_en;
    assign eng_sha1      = q.sha1;
    assign eng_close     = q.close;
    assign eng_len       = q.len;
    assign eng_digest_in = base_dig;
    assign eng_count_in  = base_cnt;
    assign eng_block     = q.blk;

    AST_DIG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (sel == RG_DIG) && (state != PS_IDLE) && !pass_end) |=> $stable(q.dig)); // R13
    AST_DMA_IN_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (state == PS_COLLECT)); // R11
    AST_CNT_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PS_RUN) && !pass_end && !srst_busy) |=> $stable(q.cnt)); // R7
endmodule

// File: tb/hfe_front_bench.sv
`timescale 1ns/1ps
module hfe_front_bench;
    import hfe_pkg::*;

    localparam int         RSTC = 4;
    localparam logic [3:0] MAJ  = 4'd2;
    localparam logic [3:0] MIN  = 4'd1;
    localparam int         LAT  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         bus_sel, bus_wr;
    logic [6:0]   bus_addr;
    logic [31:0]  bus_wdata, bus_rdata;
    logic         irq, dma_req, eng_start, eng_sha1, eng_close, eng_done;
    logic [26:0]  eng_len;
    logic [159:0] eng_digest_in, eng_digest_out;
    logic [31:0]  eng_count_in;
    logic [511:0] eng_block;

    hfe_front #(.RST_CYCLES(RSTC), .REV_MAJOR(MAJ), .REV_MINOR(MIN)) u_hfe_front (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
        .eng_start(eng_start), .eng_sha1(eng_sha1), .eng_close(eng_close), .eng_len(eng_len),
        .eng_digest_in(eng_digest_in), .eng_count_in(eng_count_in), .eng_block(eng_block),
        .eng_done(eng_done), .eng_digest_out(eng_digest_out));

    function automatic logic [159:0] mix(input logic [159:0] dg, input logic [31:0] c,
                                         input logic [511:0] b, input logic [26:0] l,
                                         input logic cl, input logic s);
        logic [31:0]  acc;
        logic [159:0] r;
        acc = 32'h0;
        for (int k = 0; k < 16; k++) acc = acc + (b[k*32 +: 32] ^ 32'(k));
        for (int j = 0; j < 5; j++)
            r[j*32 +: 32] = (dg[j*32 +: 32] ^ c) + acc * 32'(j + 1) + {5'b0, l}
                            + (cl ? 32'h100 : 32'h0) + (s ? 32'h1000 : 32'h0);
        return r;
    endfunction

    function automatic logic [159:0] iv_of(input logic s);
        return {(s ? 32'hC3D2E1F0 : 32'h0), 32'h10325476, 32'h98BADCFE, 32'hEFCDAB89, 32'h67452301};
    endfunction

    // fixed-latency engine stub
    int           stub_cnt = 0;
    logic         stub_done = 1'b0;
    logic [159:0] stub_res = '0;
    logic [159:0] cap_dig = '0;
    logic [31:0]  cap_cnt = '0;
    logic [26:0]  cap_len = '0;
    logic         cap_close = 1'b0, cap_sha1 = 1'b0;
    assign eng_done       = stub_done;
    assign eng_digest_out = stub_res;

    always @(posedge clk) begin
        stub_done <= 1'b0;
        if (eng_start) begin
            stub_cnt  <= LAT;
            stub_res  <= mix(eng_digest_in, eng_count_in, eng_block, eng_len, eng_close, eng_sha1);
            cap_dig   <= eng_digest_in;
            cap_cnt   <= eng_count_in;
            cap_len   <= eng_len;
            cap_close <= eng_close;
            cap_sha1  <= eng_sha1;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) stub_done <= 1'b1;
        end
    end

    int n_chk = 0;
    int n_err = 0;
    logic finished = 1'b0;

    logic [159:0] m_dig = '0;
    logic [31:0]  m_cnt = '0;
    logic [511:0] m_blk = '0;

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, {128'b0, bus_rdata}, {128'b0, exp});
    endtask

    task automatic do_pass(input logic s, input logic ini, input logic cl, input int len,
                           input logic ie, input logic dma);
        logic [26:0]  l;
        logic [31:0]  v;
        logic [159:0] edig, res;
        logic [31:0]  ecnt;
        int           need;
        l = 27'(len);
        bwr(OFS_MASK, {28'b0, dma, ie, 2'b00});
        if (!ini) begin
            for (int w = 0; w < 5; w++) begin
                v = $urandom;
                bwr(7'(4 * w), v);
                m_dig[w*32 +: 32] = v;
            end
            v = $urandom;
            bwr(OFS_CNT, v);
            m_cnt = v;
        end
        need = (len > 64) ? 16 : (len + 3) / 4;
        bwr(OFS_CTRL, {l, cl, ini, s, 2'b00});
        rdchk(OFS_CTRL, {l, cl, ini, s, 2'b10}, "R3 R12 control readback with input-ready");
        chk("R11 dma_req during collect", {159'b0, dma_req}, {159'b0, dma});
        bwr(OFS_CTRL, 32'h0000_0035);
        rdchk(OFS_CTRL, {l, cl, ini, s, 2'b10}, "R9 control write ignored while collecting");
        bwr(7'h00, 32'hA5A5_5A5A);
        rdchk(7'h00, m_dig[31:0], "R13 digest write ignored while busy");
        for (int k = 0; k < need; k++) begin
            v = $urandom;
            bwr(7'(28 + 4 * k), v);
            m_blk[k*32 +: 32] = v;
        end
        #1;
        chk("R4 start pulse after last word", {159'b0, eng_start}, 160'd1);
        chk("R11 dma_req low after collect", {159'b0, dma_req}, 160'd0);
        rdchk(OFS_CTRL, {l, cl, ini, s, 2'b00}, "R4 input-ready dropped");
        @(negedge clk); #1;
        chk("R4 start lasts one cycle", {159'b0, eng_start}, 160'd0);
        edig = ini ? iv_of(s) : m_dig;
        ecnt = ini ? 32'h0 : m_cnt;
        chk("R6 engine start digest", cap_dig, edig);
        chk("R6 engine start count", {128'b0, cap_cnt}, {128'b0, ecnt});
        chk("R12 engine fields", {125'b0, cap_sha1, cap_close, 6'b0, cap_len},
            {125'b0, s, cl, 6'b0, l});
        for (int t = 0; t < 100; t++) begin
            bus_addr = OFS_CTRL; #1;
            if (bus_rdata[0]) break;
            @(negedge clk);
        end
        res   = mix(edig, ecnt, m_blk, l, cl, s);
        m_dig = res;
        m_cnt = ecnt + {5'b0, l};
        rdchk(OFS_CTRL, {l, cl, ini, s, 2'b01}, "R7 output-ready set");
        for (int w = 0; w < 5; w++) rdchk(7'(4 * w), res[w*32 +: 32], "R7 digest result");
        rdchk(OFS_CNT, m_cnt, "R7 byte count advanced");
        chk("R8 irq with output-ready", {159'b0, irq}, {159'b0, ie});
        bwr(OFS_CTRL, 32'h0000_00BE);
        rdchk(OFS_CTRL, {l, cl, ini, s, 2'b01}, "R9 write without bit0 ignored when done");
        bwr(OFS_CTRL, 32'h0000_0001);
        rdchk(OFS_CTRL, {l, cl, ini, s, 2'b00}, "R9 bit0 clears output-ready");
        chk("R8 irq low after clear", {159'b0, irq}, 160'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < 5; w++) rdchk(7'(4 * w), 32'h0, "R1 digest after reset");
        rdchk(OFS_CNT, 32'h0, "R1 count after reset");
        rdchk(OFS_CTRL, 32'h0, "R1 control after reset");
        rdchk(OFS_MASK, 32'h0, "R1 mask after reset");
        rdchk(OFS_STAT, 32'h1, "R1 status after reset");
        chk("R1 outputs after reset", {157'b0, irq, dma_req, eng_start}, 160'd0);
        rdchk(OFS_REV, {24'b0, MAJ, MIN}, "R2 revision");

        // R3 zero length stays idle
        bwr(OFS_CTRL, 32'h0000_0004);
        rdchk(OFS_CTRL, 32'h0000_0004, "R3 zero length keeps idle");

        // R5 window writes while idle are dropped
        bwr(OFS_DIN, 32'hDEAD_BEEF);
        bwr(7'h28, 32'h1234_5678);
        rdchk(OFS_CTRL, 32'h0000_0004, "R5 idle window write no input-ready");

        // directed passes
        do_pass(1'b0, 1'b1, 1'b1, 16, 1'b1, 1'b0);
        bwr(7'h20, 32'hCAFE_F00D);
        do_pass(1'b1, 1'b0, 1'b0, 64, 1'b0, 1'b1);
        do_pass(1'b1, 1'b1, 1'b1, 1, 1'b1, 1'b1);
        do_pass(1'b0, 1'b0, 1'b1, 200, 1'b1, 1'b0);
        do_pass(1'b1, 1'b0, 1'b1, 63, 1'b0, 1'b0);

        // random passes
        for (int p = 0; p < 30; p++) begin
            int ln;
            ln = (($urandom % 8) == 0) ? 65 + int'($urandom % 240) : 1 + int'($urandom % 64);
            do_pass(1'($urandom), 1'($urandom), 1'($urandom), ln, 1'($urandom), 1'($urandom));
        end

        // R10 soft reset in the middle of collection
        bwr(OFS_MASK, 32'h0000_000C);
        bwr(OFS_CTRL, {27'd40, 5'b00100});
        bwr(OFS_DIN, 32'h1111_1111);
        bwr(7'h20, 32'h2222_2222);
        bwr(OFS_MASK, 32'h0000_0006);
        rdchk(OFS_STAT, 32'h0, "R10 reset-done low at start");
        repeat (RSTC - 1) @(negedge clk);
        rdchk(OFS_STAT, 32'h0, "R10 reset-done low on last reset cycle");
        @(negedge clk);
        rdchk(OFS_STAT, 32'h1, "R10 reset-done high after reset");
        m_dig = '0; m_cnt = '0; m_blk = '0;
        for (int w = 0; w < 5; w++) rdchk(7'(4 * w), 32'h0, "R10 digest cleared");
        rdchk(OFS_CNT, 32'h0, "R10 count cleared");
        rdchk(OFS_CTRL, 32'h0, "R10 control cleared");
        rdchk(OFS_MASK, 32'h0, "R10 mask cleared");
        chk("R10 outputs cleared", {157'b0, irq, dma_req, eng_start}, 160'd0);
        do_pass(1'b1, 1'b1, 1'b1, 12, 1'b1, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule